// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers seen by a processor core, with storage that changes under the current operating mode. User and System modes see one common set. The fast-interrupt mode swaps in private copies of registers 8 to 14. The four other privileged modes (interrupt, supervisor, abort, undefined) each swap in private copies of registers 13 and 14 only. Register 15 is a single physical register shared by every mode.

Two combinational read ports and one write port serve the datapath. The write port takes effect on the rising clock edge. A write-mode override lets exception-entry logic store a return address into the banked register 14 of the mode being entered, before the mode input itself has changed. An unknown mode code falls back to the User mapping and raises an error flag.

Top module: `bankrf_top`

## Requirements
- R1: After reset every physical register reads as zero, and `mode_err_o` is low while the mode input is valid.
- R2: User (`5'b10000`) and System (`5'b11111`) modes address the same storage for all sixteen registers.
- R3: In fast-interrupt mode (`5'b10001`) registers 8 to 14 are private copies. A write to them there is not seen from User mode, and User writes are not seen there.
- R4: Registers 0 to 7 are the same storage in every mode.
- R5: Interrupt (`5'b10010`), supervisor (`5'b10011`), abort (`5'b10111`) and undefined (`5'b11011`) modes each own private copies of registers 13 and 14, distinct from each other and from User and fast-interrupt copies.
- R6: In those four modes registers 8 to 12 are the User copies, not the fast-interrupt copies.
- R7: Register 15 is one physical register in every mode.
- R8: Any other mode code maps reads and writes as User mode, and `mode_err_o` goes high in the same cycle. It also goes high when the override is enabled with an unknown override code.
- R9: A read of a register being written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: With `ovr_en_i` high, `ovr_mode_i` replaces the mode for the write port only. Reads keep using `mode_i`.
- R11: The two read ports are independent. Each returns the register its own index selects, and equal indices give equal data.
- R12: With `wr_en_i` low, no register changes, whatever the write index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all storage |
| mode_i | input | 5 | Current mode code |
| rd_a_idx_i | input | 4 | Logical register index, read port A |
| rd_a_data_o | output | 32 | Read data, port A (combinational) |
| rd_b_idx_i | input | 4 | Logical register index, read port B |
| rd_b_data_o | output | 32 | Read data, port B (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Logical register index for the write |
| wr_data_i | input | 32 | Write data |
| ovr_en_i | input | 1 | Use `ovr_mode_i` for the write mapping |
| ovr_mode_i | input | 5 | Mode code applied to the write when overridden |
| mode_err_o | output | 1 | Unknown mode code on the active read or write mapping |

## Verification
A wrong mapping entry shows up as cross-talk: a value written under one mode reappears under a mode that should hold its own copy, or a shared register appears not to hold a value just written. Either is visible on a read port on the first cycle after the write. The bench therefore writes distinct values under one mode and reads them back under every other mode. A forwarding mistake shows in the cycle of the write itself, and a misdecoded mode code shows at once on the error flag.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int LOG_REGS    = 16;
    localparam int LOG_IDX_W   = $clog2(LOG_REGS);
    localparam int MODE_W      = 5;

    localparam int FAST_FIRST  = 8;
    localparam int FAST_LAST   = 14;
    localparam int FAST_COPIES = FAST_LAST - FAST_FIRST + 1;
    localparam int PRIV_FIRST  = 13;
    localparam int PRIV_COPIES = 2;
    localparam int PRIV_MODES  = 4;

    localparam int PHYS_REGS   = LOG_REGS + FAST_COPIES + PRIV_COPIES * PRIV_MODES;
    localparam int PHYS_IDX_W  = $clog2(PHYS_REGS);
    localparam int FAST_BASE   = LOG_REGS;
    localparam int PRIV_BASE   = FAST_BASE + FAST_COPIES;

    localparam logic [MODE_W-1:0] MD_USER  = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FAST  = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ   = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC   = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT   = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND   = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS   = 5'b11111;

    typedef enum logic [2:0] {
        BK_USER = 3'd0,
        BK_FAST = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

endpackage

// File: rtl/bankrf_mode_dec.sv
module bankrf_mode_dec
    import bankrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              bad_o
);

    always_comb begin
        bank_o = BK_USER;
        bad_o  = 1'b0;
        case (mode_i)
            MD_USER: bank_o = BK_USER;
            MD_SYS:  bank_o = BK_USER;
            MD_FAST: bank_o = BK_FAST;
            MD_IRQ:  bank_o = BK_IRQ;
            MD_SVC:  bank_o = BK_SVC;
            MD_ABT:  bank_o = BK_ABT;
            MD_UND:  bank_o = BK_UND;
            default: begin
                bank_o = BK_USER;
                bad_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bankrf_map.sv
module bankrf_map
    import bankrf_pkg::*;
(
    input  bank_e                 bank_i,
    input  logic [LOG_IDX_W-1:0]  idx_i,
    output logic [PHYS_IDX_W-1:0] phys_o
);

    localparam logic [LOG_IDX_W-1:0] FAST_LO_IDX = LOG_IDX_W'(FAST_FIRST);
    localparam logic [LOG_IDX_W-1:0] FAST_HI_IDX = LOG_IDX_W'(FAST_LAST);
    localparam logic [LOG_IDX_W-1:0] PRIV_LO_IDX = LOG_IDX_W'(PRIV_FIRST);
    localparam logic [LOG_IDX_W-1:0] PRIV_HI_IDX = LOG_IDX_W'(PRIV_FIRST + PRIV_COPIES - 1);

    logic                  in_fast_range;
    logic                  in_priv_range;
    logic [PHYS_IDX_W-1:0] fast_off;
    logic [PHYS_IDX_W-1:0] priv_off;
    logic [PHYS_IDX_W-1:0] priv_slot;

    assign in_fast_range = (idx_i >= FAST_LO_IDX) && (idx_i <= FAST_HI_IDX);
    assign in_priv_range = (idx_i >= PRIV_LO_IDX) && (idx_i <= PRIV_HI_IDX);
    assign fast_off      = PHYS_IDX_W'(idx_i - FAST_LO_IDX);
    assign priv_off      = PHYS_IDX_W'(idx_i - PRIV_LO_IDX);

    always_comb begin
        priv_slot = '0;
        case (bank_i)
            BK_IRQ:  priv_slot = PHYS_IDX_W'(0 * PRIV_COPIES);
            BK_SVC:  priv_slot = PHYS_IDX_W'(1 * PRIV_COPIES);
            BK_ABT:  priv_slot = PHYS_IDX_W'(2 * PRIV_COPIES);
            BK_UND:  priv_slot = PHYS_IDX_W'(3 * PRIV_COPIES);
            default: priv_slot = '0;
        endcase
    end

    always_comb begin
        phys_o = PHYS_IDX_W'(idx_i);
        if (bank_i == BK_FAST) begin
            if (in_fast_range) begin
                phys_o = PHYS_IDX_W'(FAST_BASE) + fast_off;
            end
        end else if (bank_i != BK_USER) begin
            if (in_priv_range) begin
                phys_o = PHYS_IDX_W'(PRIV_BASE) + priv_slot + priv_off;
            end
        end
    end

endmodule

// File: rtl/bankrf_store.sv
module bankrf_store
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_RD = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [PHYS_IDX_W-1:0]             wr_phys_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    input  logic [NUM_RD-1:0][PHYS_IDX_W-1:0] rd_phys_i,
    output logic [NUM_RD-1:0][DATA_W-1:0]     rd_data_o
);

    typedef struct packed {
        logic [PHYS_REGS-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.regs[wr_phys_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data_o[p] = st_q.regs[rd_phys_i[p]];
    end

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [LOG_IDX_W-1:0] rd_a_idx_i,
    output logic [DATA_W-1:0]    rd_a_data_o,
    input  logic [LOG_IDX_W-1:0] rd_b_idx_i,
    output logic [DATA_W-1:0]    rd_b_data_o,
    input  logic                 wr_en_i,
    input  logic [LOG_IDX_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 ovr_en_i,
    input  logic [MODE_W-1:0]    ovr_mode_i,
    output logic                 mode_err_o
);

    localparam int NUM_RD = 2;

    bank_e                             rd_bank;
    bank_e                             wr_bank;
    logic                              rd_bad;
    logic                              wr_bad;
    logic [MODE_W-1:0]                 wr_mode;
    logic [NUM_RD-1:0][LOG_IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][PHYS_IDX_W-1:0] rd_phys;
    logic [NUM_RD-1:0][DATA_W-1:0]     rd_data;
    logic [PHYS_IDX_W-1:0]             wr_phys;

    assign wr_mode = ovr_en_i ? ovr_mode_i : mode_i;

    bankrf_mode_dec u_rd_dec (
        .mode_i (mode_i),
        .bank_o (rd_bank),
        .bad_o  (rd_bad)
    );

    bankrf_mode_dec u_wr_dec (
        .mode_i (wr_mode),
        .bank_o (wr_bank),
        .bad_o  (wr_bad)
    );

    assign mode_err_o = rd_bad | wr_bad;

    assign rd_idx[0]   = rd_a_idx_i;
    assign rd_idx[1]   = rd_b_idx_i;
    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_map
        bankrf_map u_map (
            .bank_i (rd_bank),
            .idx_i  (rd_idx[p]),
            .phys_o (rd_phys[p])
        );
    end

    bankrf_map u_wr_map (
        .bank_i (wr_bank),
        .idx_i  (wr_idx_i),
        .phys_o (wr_phys)
    );

    bankrf_store #(
        .DATA_W (DATA_W),
        .NUM_RD (NUM_RD)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_phys_i (wr_phys),
        .wr_data_i (wr_data_i),
        .rd_phys_i (rd_phys),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MODE_W-1:0]    mode_i,
    input logic [LOG_IDX_W-1:0] rd_a_idx_i,
    input logic [DATA_W-1:0]    rd_a_data_o,
    input logic [LOG_IDX_W-1:0] rd_b_idx_i,
    input logic [DATA_W-1:0]    rd_b_data_o,
    input logic                 wr_en_i,
    input logic [LOG_IDX_W-1:0] wr_idx_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic                 ovr_en_i,
    input logic [MODE_W-1:0]    ovr_mode_i,
    input logic                 mode_err_o
);

    function automatic logic known_mode(input logic [MODE_W-1:0] m);
        return (m == 5'b10000) || (m == 5'b10001) || (m == 5'b10010) ||
               (m == 5'b10011) || (m == 5'b10111) || (m == 5'b11011) ||
               (m == 5'b11111);
    endfunction

    // R9
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i && !ovr_en_i) && mode_i == $past(mode_i) &&
         rd_a_idx_i == $past(wr_idx_i))
        |-> rd_a_data_o == $past(wr_data_i));

    // R7
    shared_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_idx_i) == 4'd15 && rd_a_idx_i == 4'd15)
        |-> rd_a_data_o == $past(wr_data_i));

    // R4
    shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_idx_i) < 4'd8 &&
         rd_b_idx_i == $past(wr_idx_i))
        |-> rd_b_data_o == $past(wr_data_i));

    // R11
    port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == rd_b_idx_i) |-> rd_a_data_o == rd_b_data_o);

    // R12
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i) && $stable(mode_i) && $stable(rd_a_idx_i))
        |-> $stable(rd_a_data_o));

    // R8
    mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o == (!known_mode(mode_i) || (ovr_en_i && !known_mode(ovr_mode_i))));

endmodule

bind bankrf_top bankrf_chk #(.DATA_W(DATA_W)) u_bankrf_chk (.*);

// File: tb/bankrf_top_bench.sv
module bankrf_top_bench;

    localparam logic [4:0] USR = 5'b10000;
    localparam logic [4:0] FIQ = 5'b10001;
    localparam logic [4:0] IRQ = 5'b10010;
    localparam logic [4:0] SVC = 5'b10011;
    localparam logic [4:0] ABT = 5'b10111;
    localparam logic [4:0] UND = 5'b11011;
    localparam logic [4:0] SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = USR;
    logic [3:0]  rd_a_idx_i = '0;
    logic [31:0] rd_a_data_o;
    logic [3:0]  rd_b_idx_i = '0;
    logic [31:0] rd_b_data_o;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        ovr_en_i = 1'b0;
    logic [4:0]  ovr_mode_i = USR;
    logic        mode_err_o;

    always #5 clk = ~clk;

    bankrf_top u_bankrf_top (.*);

    typedef struct packed {
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        logic        use_b;
        logic        exp_err;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;

    task automatic cyc(input logic [4:0] md, input logic we, input logic [3:0] widx,
                       input logic [31:0] wdat, input logic oe, input logic [4:0] om,
                       input logic [3:0] ra, input logic [31:0] ea,
                       input logic chk_b, input logic [3:0] rb, input logic [31:0] eb,
                       input logic ee, input logic do_chk, input string tag);
        @(posedge clk);
        #1;
        mode_i = md; wr_en_i = we; wr_idx_i = widx; wr_data_i = wdat;
        ovr_en_i = oe; ovr_mode_i = om; rd_a_idx_i = ra; rd_b_idx_i = rb;
        if (do_chk) begin
            exp_q.push_back('{exp_a: ea, exp_b: eb, use_b: chk_b, exp_err: ee});
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [4:0] md, input logic [3:0] idx, input logic [31:0] d);
        cyc(md, 1'b1, idx, d, 1'b0, USR, 4'd0, '0, 1'b0, 4'd0, '0, 1'b0, 1'b0, "");
    endtask

    task automatic rd(input logic [4:0] md, input logic [3:0] ra, input logic [31:0] ea,
                      input logic [3:0] rb, input logic [31:0] eb, input logic ee,
                      input string tag);
        cyc(md, 1'b0, 4'd0, '0, 1'b0, USR, ra, ea, 1'b1, rb, eb, ee, 1'b1, tag);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            string tg;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_checks++;
            if (rd_a_data_o !== it.exp_a) begin
                n_errors++;
                $display("FAIL %s port A: got %h expected %h", tg, rd_a_data_o, it.exp_a);
            end
            if (it.use_b) begin
                n_checks++;
                if (rd_b_data_o !== it.exp_b) begin
                    n_errors++;
                    $display("FAIL %s port B: got %h expected %h", tg, rd_b_data_o, it.exp_b);
                end
            end
            n_checks++;
            if (mode_err_o !== it.exp_err) begin
                n_errors++;
                $display("FAIL %s error flag: got %b expected %b", tg, mode_err_o, it.exp_err);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: cleared storage, in several modes
        rd(USR, 4'd0, 32'h0, 4'd15, 32'h0, 1'b0, "R1");
        rd(FIQ, 4'd8, 32'h0, 4'd14, 32'h0, 1'b0, "R1");
        rd(UND, 4'd13, 32'h0, 4'd7, 32'h0, 1'b0, "R1");

        for (int i = 0; i < 16; i++) wr(USR, 4'(i), 32'h1000_0000 + 32'(i));

        // R2: system sees the user set
        rd(SYS, 4'd5, 32'h1000_0005, 4'd15, 32'h1000_000F, 1'b0, "R2");
        rd(SYS, 4'd13, 32'h1000_000D, 4'd8, 32'h1000_0008, 1'b0, "R2");
        // R3: fast copies untouched by user writes
        rd(FIQ, 4'd8, 32'h0, 4'd12, 32'h0, 1'b0, "R3");
        // R4: low registers shared
        rd(FIQ, 4'd3, 32'h1000_0003, 4'd7, 32'h1000_0007, 1'b0, "R4");
        rd(ABT, 4'd0, 32'h1000_0000, 4'd6, 32'h1000_0006, 1'b0, "R4");

        wr(FIQ, 4'd8, 32'hA8);
        wr(FIQ, 4'd14, 32'hAE);
        // R3: fast writes stay private
        rd(USR, 4'd8, 32'h1000_0008, 4'd14, 32'h1000_000E, 1'b0, "R3");
        rd(FIQ, 4'd8, 32'hA8, 4'd14, 32'hAE, 1'b0, "R3");

        wr(IRQ, 4'd13, 32'hB0D);
        wr(IRQ, 4'd14, 32'hB0E);
        wr(SVC, 4'd13, 32'hC0D);
        wr(SVC, 4'd14, 32'hC0E);
        wr(ABT, 4'd13, 32'hD0D);
        wr(UND, 4'd13, 32'hE0D);
        // R5: separate copies of 13 and 14 per privileged mode
        rd(IRQ, 4'd13, 32'hB0D, 4'd14, 32'hB0E, 1'b0, "R5");
        rd(SVC, 4'd13, 32'hC0D, 4'd14, 32'hC0E, 1'b0, "R5");
        rd(ABT, 4'd13, 32'hD0D, 4'd14, 32'h0, 1'b0, "R5");
        rd(UND, 4'd13, 32'hE0D, 4'd14, 32'h0, 1'b0, "R5");
        rd(USR, 4'd13, 32'h1000_000D, 4'd14, 32'h1000_000E, 1'b0, "R5");
        rd(FIQ, 4'd13, 32'h0, 4'd14, 32'hAE, 1'b0, "R5");
        // R6: 8..12 in privileged modes are the user copies
        rd(IRQ, 4'd8, 32'h1000_0008, 4'd12, 32'h1000_000C, 1'b0, "R6");
        rd(SVC, 4'd10, 32'h1000_000A, 4'd11, 32'h1000_000B, 1'b0, "R6");

        // R7: one program counter for every mode
        wr(SVC, 4'd15, 32'hF00F);
        rd(USR, 4'd15, 32'hF00F, 4'd15, 32'hF00F, 1'b0, "R7");
        rd(FIQ, 4'd15, 32'hF00F, 4'd0, 32'h1000_0000, 1'b0, "R7");

        // R8: unknown mode maps as user and flags
        rd(5'b00000, 4'd13, 32'h1000_000D, 4'd8, 32'h1000_0008, 1'b1, "R8");
        wr(5'b10100, 4'd8, 32'h77);
        rd(USR, 4'd8, 32'h77, 4'd9, 32'h1000_0009, 1'b0, "R8");
        rd(FIQ, 4'd8, 32'hA8, 4'd9, 32'h0, 1'b0, "R8");

        // R9: same-cycle read returns the old value
        cyc(USR, 1'b1, 4'd2, 32'h2222, 1'b0, USR, 4'd2, 32'h1000_0002,
            1'b1, 4'd2, 32'h1000_0002, 1'b0, 1'b1, "R9");
        rd(USR, 4'd2, 32'h2222, 4'd3, 32'h1000_0003, 1'b0, "R9");

        // R10: override steers the write only
        cyc(USR, 1'b1, 4'd14, 32'h5E5E, 1'b1, SVC, 4'd14, 32'h1000_000E,
            1'b1, 4'd13, 32'h1000_000D, 1'b0, 1'b1, "R10");
        rd(SVC, 4'd14, 32'h5E5E, 4'd13, 32'hC0D, 1'b0, "R10");
        rd(USR, 4'd14, 32'h1000_000E, 4'd13, 32'h1000_000D, 1'b0, "R10");
        // R8: unknown override code flags and falls back to user
        cyc(USR, 1'b1, 4'd1, 32'h1111, 1'b1, 5'b00000, 4'd0, 32'h1000_0000,
            1'b1, 4'd1, 32'h1000_0001, 1'b1, 1'b1, "R8");
        rd(USR, 4'd1, 32'h1111, 4'd0, 32'h1000_0000, 1'b0, "R8");

        // R12: disabled write leaves storage alone
        cyc(USR, 1'b0, 4'd3, 32'hDEAD, 1'b0, USR, 4'd3, 32'h1000_0003,
            1'b1, 4'd4, 32'h1000_0004, 1'b0, 1'b1, "R12");
        rd(USR, 4'd3, 32'h1000_0003, 4'd4, 32'h1000_0004, 1'b0, "R12");
        // R11: ports pick independently
        rd(IRQ, 4'd14, 32'hB0E, 4'd14, 32'hB0E, 1'b0, "R11");
        rd(FIQ, 4'd2, 32'h2222, 4'd8, 32'hA8, 1'b0, "R11");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule